// File: doc/BRIEF.md
# Read Prefetch Controller for a Bus-Master Read Path

This block turns a local read request into a run of 32-bit word fetches on an outgoing master read path. A two-bit size code, sampled when the request is accepted, decides the run length. Code 0 keeps fetching until the local side signals that its access is over. Codes 1 to 3 cap the run at a fixed number of words. An optional page-stop setting ends a run after the last word of a 4 KB page. A single-word request ignores the size code entirely.

While a run is active, a full read FIFO pauses word requests. Depending on a hold setting, the pause is handled in one of two ways. In release mode the block asks the bus engine to give up the bus. In hold mode it keeps the bus and tells the engine to deassert the initiator-ready signal. Either way, fetching resumes at the next word address once the FIFO has space.

The outgoing address takes its low 16 bits from the advancing local word address. The upper 16 bits come from a remap field. For I/O requests the upper bits can instead be forced to zero. Memory requests and I/O requests each have their own decode enable, and a request whose kind is not enabled is ignored.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: While reset is held, and after it is released with no request, `fetch_req`, `bus_release`, `irdy_stall` and `xfer_end` are all 0.
- R2: A request with `rd_is_io`=0 starts a run only if `cfg_mem_en`=1. A request with `rd_is_io`=1 starts a run only if `cfg_io_en`=1. Any other request produces no fetch and no `xfer_end`.
- R3: When `rd_single`=0, size codes 2'b01, 2'b10 and 2'b11 end the run after exactly 4, 8 and 16 accepted words. Here an accepted word is a cycle with `fetch_req`=1 and `word_ack`=1.
- R4: Size code 2'b00 keeps requesting words until `rd_done` is 1. In a cycle where `rd_done` is 1, `fetch_req` is 0 and the run ends.
- R5: With `cfg_page_stop`=1, the run ends after the accepted word whose address bits [11:2] are all ones, if no earlier limit ends it. With `cfg_page_stop`=0, the run continues across the page boundary.
- R6: The n-th accepted word of a run, counting from 0, has `fetch_addr[15:0]` equal to `rd_addr[15:0]` plus 4n, modulo 2^16, with bits [1:0] equal to 0.
- R7: `fetch_addr[31:16]` is 0 when the run is an I/O run and `cfg_io_zero_hi`=1. Otherwise it equals `cfg_remap_hi`.
- R8: While a run is active and `fifo_full`=1 with `cfg_hold_bus`=0, `bus_release`=1, `irdy_stall`=0 and `fetch_req`=0.
- R9: While a run is active and `fifo_full`=1 with `cfg_hold_bus`=1, `irdy_stall`=1, `bus_release`=0 and `fetch_req`=0.
- R10: After `fifo_full` returns to 0, fetching resumes at the next unfetched word, and the run still delivers its full word count.
- R11: A request with `rd_single`=1 fetches exactly one word, whatever the size code.
- R12: `xfer_end` is 1 for exactly one cycle. That cycle is the one after the edge that accepted the last word or that saw `rd_done`.
- R13: `rd_req` is ignored while a run is active. The run's addresses and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mem_en | input | 1 | Decode enable for memory requests |
| cfg_io_en | input | 1 | Decode enable for I/O requests |
| cfg_pf_size | input | 2 | Prefetch size code (00 open-ended, 01/10/11 capped) |
| cfg_page_stop | input | 1 | End runs at a 4 KB page end |
| cfg_hold_bus | input | 1 | 1: stall with IRDY on full FIFO; 0: release the bus |
| cfg_io_zero_hi | input | 1 | Force upper address bits to zero for I/O runs |
| cfg_remap_hi | input | 16 | Upper outgoing address bits |
| rd_req | input | 1 | Local read request strobe |
| rd_is_io | input | 1 | Request is an I/O access |
| rd_single | input | 1 | Request wants one word only |
| rd_addr | input | 32 | Local start address |
| rd_done | input | 1 | Local access has ended |
| fifo_full | input | 1 | Read FIFO has no space |
| word_ack | input | 1 | Bus engine takes the requested word this cycle |
| fetch_req | output | 1 | Word fetch request to the bus engine |
| fetch_addr | output | 32 | Address of the requested word |
| bus_release | output | 1 | Engine should give up the bus |
| irdy_stall | output | 1 | Engine should hold the bus with IRDY deasserted |
| xfer_end | output | 1 | One-cycle end-of-run pulse |

## Verification
Two cases are the hardest to reach from the ports. In the first, the page-stop limit and a size cap compete in the same run. In the second, the 16-bit low address wraps while the upper bits come from the remap field. The bench gets to both by starting runs a few words before a page end (3, 8 and 2 words away) and at the top of the 16-bit space. It does this for every size code, with page stop both off and on, and with acknowledge gaps in half of the runs. Full-FIFO pauses are injected in the middle of a run, and a competing request is presented during the pause. This shows that pausing and ignoring that request leave the word sequence intact.

// File: rtl/rpf_pkg.sv
// Shared types for the read prefetch controller.
// Assumes: one run at a time; size code fixed for the run once accepted.
package rpf_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rpf_state_e;

    typedef enum logic [1:0] {
        PF_OPEN = 2'b00,
        PF_X1   = 2'b01,
        PF_X2   = 2'b10,
        PF_X4   = 2'b11
    } pf_code_e;

    typedef struct packed {
        logic io;      // run came from an I/O request
        logic capped;  // run has a word limit
        logic bound;   // run stops at a page end
    } txn_attr_t;

endpackage

// File: rtl/rpf_size_dec.sv
// Size decoder: maps the prefetch code to a word limit.
// Assumes: CNT_W can hold BASE_WORDS*4. A single-word request overrides the code.
module rpf_size_dec
    import rpf_pkg::*;
#(
    parameter int BASE_WORDS = 4,
    parameter int CNT_W      = 5
) (
    input  logic [1:0]       pf_code,
    input  logic             single,
    output logic             capped,
    output logic [CNT_W-1:0] limit
);

    // Decode the code into a capped flag and a word limit.
    always_comb begin
        capped = 1'b1;
        limit  = CNT_W'(1);
        if (!single) begin
            unique case (pf_code_e'(pf_code))
                PF_OPEN: begin
                    capped = 1'b0;
                    limit  = '0;
                end
                PF_X1:   limit = CNT_W'(BASE_WORDS);
                PF_X2:   limit = CNT_W'(BASE_WORDS * 2);
                default: limit = CNT_W'(BASE_WORDS * 4);
            endcase
        end
    end

endmodule

// File: rtl/rpf_word_ctr.sv
// Word counter and word address for the current run.
// Assumes: load and adv never coincide (load only happens in idle).
module rpf_word_ctr #(
    parameter int WA_W  = 14,
    parameter int PW    = 10,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WA_W-1:0]  load_word,
    input  logic             adv,
    output logic [WA_W-1:0]  word_addr,
    output logic [CNT_W-1:0] cnt,
    output logic             page_end
);

    // Restart at a new run; step address and count on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_addr <= '0;
            cnt       <= '0;
        end else if (load) begin
            word_addr <= load_word;
            cnt       <= '0;
        end else if (adv) begin
            word_addr <= word_addr + WA_W'(1);
            cnt       <= cnt + CNT_W'(1);
        end
    end

    // The current word is the last one in its page.
    always_comb page_end = &word_addr[PW-1:0];

endmodule

// File: rtl/rpf_seq.sv
// Run sequencer: idle/run control, FIFO-full handling and end pulse.
// Assumes: last_word is valid while running; local_done takes priority over a fetch.
module rpf_seq
    import rpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fifo_full,
    input  logic hold_mode,
    input  logic local_done,
    input  logic word_ack,
    input  logic last_word,
    output logic running,
    output logic fetch_req,
    output logic bus_release,
    output logic irdy_stall,
    output logic load,
    output logic adv,
    output logic xfer_end
);

    rpf_state_e state_q, state_d;
    logic       end_d;

    // Next state and per-cycle controls.
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        adv         = 1'b0;
        end_d       = 1'b0;
        fetch_req   = 1'b0;
        bus_release = 1'b0;
        irdy_stall  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
                if (start) state_d = ST_RUN;
            end
            default: begin
                bus_release = fifo_full && !hold_mode;
                irdy_stall  = fifo_full && hold_mode;
                fetch_req   = !fifo_full && !local_done;
                adv         = fetch_req && word_ack;
                if (local_done || (adv && last_word)) begin
                    state_d = ST_IDLE;
                    end_d   = 1'b1;
                end
            end
        endcase
    end

    // State and end-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            xfer_end <= 1'b0;
        end else begin
            state_q  <= state_d;
            xfer_end <= end_d;
        end
    end

    always_comb running = (state_q == ST_RUN);

    // The end pulse never lasts two cycles.
    assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !xfer_end);

    // Release and stall are never requested together.
    assert_full_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_release && irdy_stall));

    // A full FIFO never coexists with a word request.
    assert_full_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fifo_full) |-> !fetch_req);

endmodule

// File: rtl/rd_prefetch_ctl.sv
// Read prefetch controller top: decodes requests, fixes the run attributes,
// and builds the outgoing address.
// Assumes: configuration inputs are static while a run is active.
module rd_prefetch_ctl
    import rpf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int REMAP_W    = 16,
    parameter int PAGE_W     = 12,
    parameter int BASE_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mem_en,
    input  logic               cfg_io_en,
    input  logic [1:0]         cfg_pf_size,
    input  logic               cfg_page_stop,
    input  logic               cfg_hold_bus,
    input  logic               cfg_io_zero_hi,
    input  logic [REMAP_W-1:0] cfg_remap_hi,
    input  logic               rd_req,
    input  logic               rd_is_io,
    input  logic               rd_single,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_done,
    input  logic               fifo_full,
    input  logic               word_ack,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               bus_release,
    output logic               irdy_stall,
    output logic               xfer_end
);

    localparam int LOW_W     = ADDR_W - REMAP_W;
    localparam int WA_W      = LOW_W - 2;
    localparam int PW        = PAGE_W - 2;
    localparam int MAX_WORDS = BASE_WORDS * 4;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    logic             start, running, load, adv, last_word, page_end;
    logic             capped_d;
    logic [CNT_W-1:0] limit_d, limit_q, cnt;
    logic [WA_W-1:0]  word_addr;
    txn_attr_t        attr_q;
    logic [REMAP_W-1:0] hi_bits;

    // A request is taken only when its kind is enabled.
    always_comb start = rd_req && (rd_is_io ? cfg_io_en : cfg_mem_en);

    rpf_size_dec #(
        .BASE_WORDS (BASE_WORDS),
        .CNT_W      (CNT_W)
    ) u_size (
        .pf_code (cfg_pf_size),
        .single  (rd_single),
        .capped  (capped_d),
        .limit   (limit_d)
    );

    // Hold the run attributes fixed from the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q  <= '0;
            limit_q <= '0;
        end else if (load) begin
            attr_q  <= '{io: rd_is_io, capped: capped_d, bound: cfg_page_stop};
            limit_q <= limit_d;
        end
    end

    rpf_word_ctr #(
        .WA_W  (WA_W),
        .PW    (PW),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (rd_addr[LOW_W-1:2]),
        .adv       (adv),
        .word_addr (word_addr),
        .cnt       (cnt),
        .page_end  (page_end)
    );

    // The current word closes the run by count or by page end.
    always_comb last_word = (attr_q.capped && (cnt == limit_q - CNT_W'(1)))
                          || (attr_q.bound && page_end);

    rpf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .fifo_full   (fifo_full),
        .hold_mode   (cfg_hold_bus),
        .local_done  (rd_done),
        .word_ack    (word_ack),
        .last_word   (last_word),
        .running     (running),
        .fetch_req   (fetch_req),
        .bus_release (bus_release),
        .irdy_stall  (irdy_stall),
        .load        (load),
        .adv         (adv),
        .xfer_end    (xfer_end)
    );

    // Upper bits come from the remap field unless an I/O run zeroes them.
    always_comb hi_bits = (attr_q.io && cfg_io_zero_hi) ? '0 : cfg_remap_hi;

    always_comb fetch_addr = {hi_bits, word_addr, 2'b00};

    // A capped run never counts up to its limit while running.
    assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && attr_q.capped) |-> (cnt < limit_q));

    // Consecutive requested words of one run step by one word.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && $past(fetch_req && word_ack && !last_word))
        |-> (fetch_addr[LOW_W-1:2] == $past(fetch_addr[LOW_W-1:2]) + WA_W'(1)));

    // A page-stopped run issues nothing after the last word of the page.
    assert_page_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_q.bound && fetch_req && word_ack && page_end) |=> !fetch_req);

    // I/O runs with zeroing selected carry zero upper bits.
    assert_io_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && attr_q.io && cfg_io_zero_hi) |-> (fetch_addr[ADDR_W-1:LOW_W] == '0));

    // Outputs stay quiet while no run is active.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(fetch_req || bus_release || irdy_stall));

endmodule

// File: tb/rd_prefetch_ctl_tb.sv
`timescale 1ns/1ps
module rd_prefetch_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_mem_en, cfg_io_en, cfg_page_stop, cfg_hold_bus, cfg_io_zero_hi;
    logic [1:0]  cfg_pf_size;
    logic [15:0] cfg_remap_hi;
    logic        rd_req, rd_is_io, rd_single, rd_done, fifo_full, word_ack;
    logic [31:0] rd_addr;
    logic        fetch_req, bus_release, irdy_stall, xfer_end;
    logic [31:0] fetch_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rd_prefetch_ctl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mem_en     (cfg_mem_en),
        .cfg_io_en      (cfg_io_en),
        .cfg_pf_size    (cfg_pf_size),
        .cfg_page_stop  (cfg_page_stop),
        .cfg_hold_bus   (cfg_hold_bus),
        .cfg_io_zero_hi (cfg_io_zero_hi),
        .cfg_remap_hi   (cfg_remap_hi),
        .rd_req         (rd_req),
        .rd_is_io       (rd_is_io),
        .rd_single      (rd_single),
        .rd_addr        (rd_addr),
        .rd_done        (rd_done),
        .fifo_full      (fifo_full),
        .word_ack       (word_ack),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr),
        .bus_release    (bus_release),
        .irdy_stall     (irdy_stall),
        .xfer_end       (xfer_end)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Request that must be ignored: no fetch and no end pulse for several cycles.
    task automatic expect_ignored(input bit io, input string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_is_io = io; rd_addr = 32'h0000_2000;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rd_req = 1'b0;
            #1;
            chk({tag, " fetch_req"}, {31'd0, fetch_req}, 32'd0);
            chk({tag, " xfer_end"}, {31'd0, xfer_end}, 32'd0);
        end
    endtask

    // Issue one request and follow the run, checking every word and the end.
    task automatic run_txn(input logic [15:0] low, input bit io, input int exp_words,
                           input int done_after, input int full_at, input bit gaps,
                           input string tag);
        logic [15:0] hi;
        int words, full_left;
        bit seen, full_done;
        hi = (io && cfg_io_zero_hi) ? 16'h0 : cfg_remap_hi;
        words = 0; full_left = 0; seen = 1'b0; full_done = 1'b0;
        @(negedge clk);
        rd_req = 1'b1; rd_is_io = io; rd_addr = {16'h7777, low};
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            rd_req = 1'b0; rd_done = 1'b0; fifo_full = 1'b0;
            word_ack = gaps ? (c % 3 != 2) : 1'b1;
            if (xfer_end) begin
                seen = 1'b1;
                break;
            end
            if (full_at >= 0 && !full_done && words == full_at) begin
                full_done = 1'b1;
                full_left = 3;
            end
            if (full_left > 0) begin
                fifo_full = 1'b1;
                rd_req = 1'b1;                // R13: competing request while busy
                rd_addr = 32'h0000_0100;
                full_left--;
                #1;
                chk({tag, " R8 bus_release"}, {31'd0, bus_release}, {31'd0, !cfg_hold_bus});
                chk({tag, " R9 irdy_stall"}, {31'd0, irdy_stall}, {31'd0, cfg_hold_bus});
                chk({tag, " R10 fetch_req paused"}, {31'd0, fetch_req}, 32'd0);
                continue;
            end
            if (done_after >= 0 && words == done_after) rd_done = 1'b1;
            #1;
            if (fetch_req) begin
                chk({tag, " R6 R7 R13 addr"}, fetch_addr, {hi, low + 16'(4 * words)});
                if (word_ack) words++;
            end
        end
        chk({tag, " R12 end seen"}, {31'd0, seen}, 32'd1);
        chk({tag, " R3 R4 R5 R11 words"}, words, exp_words);
        @(negedge clk);
        #1;
        chk({tag, " R12 single pulse"}, {31'd0, xfer_end}, 32'd0);
        chk({tag, " R12 idle after end"}, {31'd0, fetch_req}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lows [4];
        lows[0] = 16'h2F00; lows[1] = 16'h0FF4; lows[2] = 16'h3FE0; lows[3] = 16'hFFF8;
        rst_n = 1'b0;
        cfg_mem_en = 0; cfg_io_en = 0; cfg_pf_size = 0; cfg_page_stop = 0;
        cfg_hold_bus = 0; cfg_io_zero_hi = 0; cfg_remap_hi = 16'hA5C3;
        rd_req = 0; rd_is_io = 0; rd_single = 0; rd_addr = 0; rd_done = 0;
        fifo_full = 0; word_ack = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset fetch_req", {31'd0, fetch_req}, 32'd0);
        chk("R1 reset xfer_end", {31'd0, xfer_end}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 idle release", {31'd0, bus_release}, 32'd0);
        chk("R1 idle stall", {31'd0, irdy_stall}, 32'd0);
        chk("R1 idle fetch", {31'd0, fetch_req}, 32'd0);

        // R2: decode enables gate each kind of request
        expect_ignored(1'b0, "R2 mem disabled");
        expect_ignored(1'b1, "R2 io disabled");
        cfg_mem_en = 1'b1;
        expect_ignored(1'b1, "R2 io still disabled");
        cfg_pf_size = 2'b01;
        run_txn(16'h0040, 1'b0, 4, -1, -1, 1'b0, "R2 mem enabled");
        cfg_io_en = 1'b1;
        cfg_mem_en = 1'b0;
        expect_ignored(1'b0, "R2 mem disabled again");
        cfg_mem_en = 1'b1;
        cfg_io_zero_hi = 1'b1;

        // Sweep of size codes, page stop and start addresses
        for (int code = 0; code < 4; code++) begin
            for (int b = 0; b < 2; b++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    int base, wtp, expw;
                    cfg_pf_size = 2'(code);
                    cfg_page_stop = b[0];
                    base = (code == 0) ? ((ai < 2) ? 6 : 20) : (4 << (code - 1));
                    wtp = 1024 - int'(lows[ai][11:2]);
                    expw = (b == 1 && wtp < base) ? wtp : base;
                    run_txn(lows[ai], ai[0], expw, (code == 0) ? base : -1, -1, b[0],
                            $sformatf("sweep code=%0d stop=%0d start=%h", code, b, lows[ai]));
                end
            end
        end

        // R8, R10: full FIFO in release mode; R9: in hold mode
        cfg_page_stop = 1'b0;
        cfg_pf_size = 2'b11;
        cfg_hold_bus = 1'b0;
        run_txn(16'h2F00, 1'b0, 16, -1, 5, 1'b0, "R8 release");
        cfg_hold_bus = 1'b1;
        run_txn(16'h2F00, 1'b1, 16, -1, 9, 1'b1, "R9 hold");
        cfg_pf_size = 2'b00;
        run_txn(16'h1000, 1'b0, 7, 7, 2, 1'b0, "R10 open run");

        // R11: single-word requests
        rd_single = 1'b1;
        cfg_pf_size = 2'b11;
        run_txn(16'h2F00, 1'b0, 1, -1, -1, 1'b0, "R11 single x16");
        cfg_pf_size = 2'b00;
        run_txn(16'h0FFC, 1'b1, 1, -1, -1, 1'b0, "R11 single open");
        rd_single = 1'b0;

        // R7: upper bits from remap when zeroing is off, for an I/O run
        cfg_io_zero_hi = 1'b0;
        cfg_pf_size = 2'b01;
        run_txn(16'h0100, 1'b1, 4, -1, -1, 1'b0, "R7 io remap");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule